// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Monitor

This block sits beside a master on a shared two-wire bus and tells it whether the bus may be claimed. It samples the data line (SDA) and clock line (SCL) through a short chain of flip-flops and compares each new sample with the one before it. A START is seen when SDA falls while SCL stays high. A STOP is seen when SDA rises while SCL stays high. Each condition sets its own sticky flag and clears the other one.

The bus counts as free in two cases: the last condition seen was a STOP, or no condition has been seen since reset or since the block was last disabled. When a STOP ends a busy period and the interrupt enable is high, the block raises a one-cycle interrupt pulse. The monitor keeps running while the local master is idle or has lost arbitration. This means a master that backed off can wait for the pulse and then try again.

Top module: `i2cmon_top`

## Requirements
- R1: After reset both flags are low, `bus_free_o` is high and `irq_o` is low. The line samplers reset to the idle level 1, so the first real samples do not produce false edges.
- R2: When enabled, an SDA fall while SCL is high in both the old and the new sample sets `start_seen_o`, clears `stop_seen_o` and drives `bus_free_o` low.
- R3: When enabled, an SDA rise while SCL is high in both samples sets `stop_seen_o`, clears `start_seen_o` and drives `bus_free_o` high.
- R4: An SDA change in a sample pair where SCL is low in either sample leaves both flags and `irq_o` unchanged.
- R5: An SCL change while SDA stays steady, or no change at all, leaves both flags and `irq_o` unchanged.
- R6: A START while `start_seen_o` is already set keeps `start_seen_o` high and `bus_free_o` low, and raises no interrupt.
- R7: While `enable_i` is low, both flags read 0 from the second clock edge onward. Every START and STOP is ignored during that time, and `irq_o` stays low.
- R8: A STOP seen while `start_seen_o` is set, with `enable_i` and `irq_en_i` both high, drives `irq_o` high for exactly one clock cycle.
- R9: A STOP raises no interrupt when `irq_en_i` is low or when the bus was already free.
- R10: With the default two sampling stages, a line change made before clock edge k is seen at edge k. It updates the flags on edge k+2, and the flags still hold their old values between edges k+1 and k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | Raw data line level |
| scl_i | input | 1 | Raw clock line level |
| enable_i | input | 1 | Module enable; low clears and holds both flags |
| irq_en_i | input | 1 | Allows the STOP-ends-busy interrupt |
| start_seen_o | output | 1 | Sticky flag: a START was the last condition seen |
| stop_seen_o | output | 1 | Sticky flag: a STOP was the last condition seen |
| bus_free_o | output | 1 | Bus may be claimed by a local master |
| irq_o | output | 1 | One-cycle pulse when a STOP ends a busy period |

## Verification
On every cycle, the assertions check that the two flags are never high together. They also check that a detected START or STOP lands in the flags on the next edge, that disabling clears the flags, and that each interrupt is a single cycle backed by a busy bus and an enabled interrupt. Some behaviours only the bench scenarios can show. These are the exact pipeline latency from the pins and the fact that data-bit activity while SCL is low is ignored. The bench also shows the whole flag history over every three-step sequence of line states, with and without the interrupt enable.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_t;

    localparam line_t LINE_IDLE = '{sda: 1'b1, scl: 1'b1};

    typedef struct packed {
        logic start_seen;
        logic stop_seen;
        logic irq;
    } flag_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= {STAGES{RESET_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[LAST];

endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t cur,
    output logic  start_det,
    output logic  stop_det
);
    typedef struct packed {
        line_t prev;
    } det_t;

    det_t dt_d, dt_q;
    logic scl_held;

    always_comb begin
        dt_d      = dt_q;
        dt_d.prev = cur;
        scl_held  = dt_q.prev.scl & cur.scl;
        start_det = scl_held &  dt_q.prev.sda & ~cur.sda;
        stop_det  = scl_held & ~dt_q.prev.sda &  cur.sda;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dt_q.prev <= LINE_IDLE;
        end else begin
            dt_q <= dt_d;
        end
    end

    // R4: no condition can come out of a sample pair where SCL is low
    a_r4_scl_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> (cur.scl && $past(cur.scl)));

endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic irq_en,
    input  logic start_det,
    input  logic stop_det,
    output logic start_seen,
    output logic stop_seen,
    output logic bus_free,
    output logic irq
);
    flag_t fl_d, fl_q;
    logic  free_now;

    always_comb begin
        fl_d     = fl_q;
        free_now = fl_q.stop_seen | (~fl_q.start_seen & ~fl_q.stop_seen);
        fl_d.irq = 1'b0;
        if (!enable) begin
            fl_d.start_seen = 1'b0;
            fl_d.stop_seen  = 1'b0;
        end else if (start_det) begin
            fl_d.start_seen = 1'b1;
            fl_d.stop_seen  = 1'b0;
        end else if (stop_det) begin
            fl_d.start_seen = 1'b0;
            fl_d.stop_seen  = 1'b1;
            fl_d.irq        = irq_en & ~free_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign start_seen = fl_q.start_seen;
    assign stop_seen  = fl_q.stop_seen;
    assign bus_free   = free_now;
    assign irq        = fl_q.irq;

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_q.start_seen, fl_q.stop_seen}));

    a_r2_start_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det) |=> (start_seen && !stop_seen && !bus_free));

    a_r3_stop_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det) |=> (stop_seen && !start_seen && bus_free));

    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_seen && !stop_seen && !irq));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(irq_en) && $past(start_seen) && stop_seen));

endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_i,
    input  logic scl_i,
    input  logic enable_i,
    input  logic irq_en_i,
    output logic start_seen_o,
    output logic stop_seen_o,
    output logic bus_free_o,
    output logic irq_o
);
    localparam int LINE_W = $bits(line_t);

    line_t raw_line, sync_line;
    logic  start_det, stop_det;

    assign raw_line = '{sda: sda_i, scl: scl_i};

    i2cmon_sync #(
        .STAGES   (SYNC_STAGES),
        .WIDTH    (LINE_W),
        .RESET_VAL(LINE_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_line),
        .dout (sync_line)
    );

    i2cmon_cond_detect u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (sync_line),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2cmon_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable_i),
        .irq_en    (irq_en_i),
        .start_det (start_det),
        .stop_det  (stop_det),
        .start_seen(start_seen_o),
        .stop_seen (stop_seen_o),
        .bus_free  (bus_free_o),
        .irq       (irq_o)
    );

    // R6: a second START never frees the bus or raises the interrupt
    a_r6_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && start_det && start_seen_o) |=> (!bus_free_o && !irq_o));

endmodule

// File: tb/sim_i2cmon_top.sv
`timescale 1ns/1ps
module sim_i2cmon_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_i = 1'b1, scl_i = 1'b1, enable_i = 1'b0, irq_en_i = 1'b0;
    logic start_seen_o, stop_seen_o, bus_free_o, irq_o;

    int checks = 0;
    int failures = 0;
    logic m_s = 1'b0, m_p = 1'b0, m_sda = 1'b1, m_scl = 1'b1;

    always #2.5 clk = ~clk;

    i2cmon_top u0 (
        .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i),
        .enable_i(enable_i), .irq_en_i(irq_en_i),
        .start_seen_o(start_seen_o), .stop_seen_o(stop_seen_o),
        .bus_free_o(bus_free_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s got=%0d exp=%0d", tag, what, got, exp);
        end
    endtask

    task automatic chk_flags(input string tag);
        chk(tag, "start_seen", int'(start_seen_o), int'(m_s));
        chk(tag, "stop_seen", int'(stop_seen_o), int'(m_p));
        chk(tag, "bus_free", int'(bus_free_o), int'(m_p || (!m_s && !m_p)));
    endtask

    task automatic step(input logic nsda, input logic nscl);
        logic st, sp, en, exp_irq;
        int hi;
        string tg, itg;
        @(negedge clk);
        en = enable_i;
        st = en && m_scl && nscl && m_sda && !nsda;
        sp = en && m_scl && nscl && !m_sda && nsda;
        exp_irq = sp && m_s && irq_en_i;
        if (!en) tg = "R7";
        else if (st) tg = m_s ? "R6" : "R2";
        else if (sp) tg = "R3";
        else if (!(m_scl && nscl)) tg = "R4";
        else tg = "R5";
        itg = (sp && m_s && irq_en_i) ? "R8" : "R9";
        if (st) begin m_s = 1'b1; m_p = 1'b0; end
        if (sp) begin m_s = 1'b0; m_p = 1'b1; end
        m_sda = nsda; m_scl = nscl;
        sda_i = nsda; scl_i = nscl;
        hi = 0;
        repeat (5) begin
            @(negedge clk);
            if (irq_o) hi++;
        end
        chk_flags(tg);
        chk(itg, "irq_cycles", hi, int'(exp_irq));
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_flags("R1");
        chk("R1", "irq", int'(irq_o), 0);

        enable_i = 1'b1;
        repeat (3) @(negedge clk);

        // R10: latency of a START from the pins
        sda_i = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10", "start_before_k2", int'(start_seen_o), 0);
        @(posedge clk); @(negedge clk);
        chk("R10", "start_at_k2", int'(start_seen_o), 1);
        m_sda = 1'b0; m_s = 1'b1; m_p = 1'b0;
        repeat (3) @(negedge clk);

        // R6: repeated START with the interrupt enabled
        irq_en_i = 1'b1;
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        chk("R6", "still_busy", int'(bus_free_o), 0);
        // R8: STOP ends the busy period
        step(1'b1, 1'b1);
        // R9: second STOP while already free
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);

        // Sweep of every three-step sequence of line states
        for (int ie = 0; ie < 2; ie++) begin
            irq_en_i = ie[0];
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        step(a[1], a[0]);
                        step(b[1], b[0]);
                        step(c[1], c[0]);
                    end
        end

        // R7: disable clears and ignores conditions
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk); @(negedge clk);
        m_s = 1'b0; m_p = 1'b0;
        chk_flags("R7");
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        @(negedge clk);
        enable_i = 1'b1;
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule